// File: doc/BRIEF.md
# Multi-Rail Power Sequencer and Protection Supervisor

This block is the digital control centre of a multi-output supply. The supply has a standby output, two main buck rails and a boost rail that is fed from the higher buck. The block decides, on every system clock, which converters may switch. It also applies the protection policy to the comparator flags that the analog side raises. Each main rail starts when the master enable and that rail's own enable are both high. The boost rail starts and stops with the higher buck.

The faults are handled in four different ways. A lasting over-current or undervoltage shuts rails down and latches them off until the master enable is pulsed low. A buck overvoltage turns on that rail's low-side switch for as long as the flag stays present. A boost overvoltage holds the boost switch off, also only while the flag is present. An input undervoltage or over-temperature stops everything, and operation resumes by itself once the flag clears.

Every input goes through a two-stage synchronizer. Persistence windows are counted in clock cycles. The undervoltage window is derived from a clock-frequency parameter.

Top module: `rail_supervisor`

## Requirements
- R1: `standby_on_o` is high exactly when the synchronized master enable is high, input undervoltage is low and over-temperature is low.
- R2: Rail bit positions are 0 = higher buck, 1 = lower buck, 2 = boost, in `run_o` and `force_off_o`. Bit 0 is the higher buck and bit 1 the lower buck in the two-bit rail inputs and in `crowbar_o`. `run_o[0]` follows master AND `rail_en_i[0]`. `run_o[1]` follows master AND `rail_en_i[1]`. `run_o[2]` follows `run_o[0]`. An input change reaches the outputs after two clock edges.
- R3: A buck over-current flag held for `OC_CYCLES` (default 8) consecutive synchronized samples latches that buck off, with its run low and its force-off high. A flag that lasts one sample fewer leaves the rail running. An over-current latch on the higher buck also stops the boost.
- R4: A buck undervoltage flag on either buck, held for the undervoltage window (`UV_NS` ns at `CLK_HZ`, which is 500 samples at the defaults), latches both bucks and the boost off. A flag held one sample fewer has no effect.
- R5: A boost undervoltage flag held for the same window latches all three converters off.
- R6: A latched fault persists while the master enable stays high. It is cleared only by a low master enable or by reset.
- R7: A buck overvoltage flag drives that buck's `crowbar_o` bit high and its run low for as long as the flag lasts. The other rails are unaffected and nothing latches.
- R8: A boost overvoltage flag drives `force_off_o[2]` high and `run_o[2]` low while it lasts, without latching.
- R9: Input undervoltage or over-temperature drops standby and all runs, and drives all force-off bits high. Operation resumes by itself when the flag clears.
- R10: A persistence count restarts whenever its flag drops for a sample. Two bursts that are each one sample short never latch.
- R11: `fault_latched_o` is high while any latched fault is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_en_i | input | 1 | Master enable; low shuts everything down and clears latched faults |
| rail_en_i | input | 2 | Per-buck enables (bit 0 higher buck, bit 1 lower buck) |
| in_uv_i | input | 1 | Input undervoltage flag |
| over_temp_i | input | 1 | Over-temperature flag |
| buck_oc_i | input | 2 | Buck over-current flags |
| buck_uv_i | input | 2 | Buck undervoltage flags |
| buck_ov_i | input | 2 | Buck overvoltage flags |
| boost_uv_i | input | 1 | Boost undervoltage flag |
| boost_ov_i | input | 1 | Boost overvoltage flag |
| standby_on_o | output | 1 | Standby regulators on |
| run_o | output | 3 | Converter run permits |
| crowbar_o | output | 2 | Force low-side switch on |
| force_off_o | output | 3 | Protective gate-off per converter |
| fault_latched_o | output | 1 | A latched fault is held |

## Verification
The bench targets the persistence boundaries: flags held exactly one sample short of the over-current and undervoltage windows, and then exactly long enough. A design with an off-by-one counter would either trip early on the short pulse or fail to trip on the exact one. Two short bursts separated by a single clear sample check that the count restarts. A counter that only pauses would add the two bursts up and latch. The bench also confirms three other behaviours. Crowbar and boost overvoltage release on their own, and a design that latched them would keep the rail stopped. Thermal and input-undervoltage shutdowns recover without a master pulse. Latched faults survive until the master enable drops, and a wrongly scoped fault would leave the wrong rail running.

// File: rtl/rail_sup_pkg.sv
package rail_sup_pkg;
  localparam int RAIL_HI  = 0;
  localparam int RAIL_LO  = 1;
  localparam int RAIL_BST = 2;
  localparam int N_BUCK   = 2;
  localparam int N_RAIL   = 3;

  function automatic int unsigned ns_to_cycles(longint unsigned hz, int unsigned ns);
    longint unsigned c;
    c = (hz / 64'd1_000_000) * longint'(ns) / 64'd1000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction
endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1, s2;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= d_i;
      s2 <= s1;
    end
  end
  assign q_o = s2;
endmodule

// File: rtl/persist_timer.sv
module persist_timer #(
  parameter int unsigned N = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic flag_i,
  output logic fire_o
);
  localparam int W = (N > 1) ? $clog2(N) : 1;
  localparam logic [W-1:0] LAST = W'(N - 1);
  logic [W-1:0] cnt;

  assign fire_o = flag_i && (cnt == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt <= '0;
    else if (clr_i || !flag_i)   cnt <= '0;  // restart on any gap
    else if (cnt != LAST)        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rail_supervisor.sv
module rail_supervisor
  import rail_sup_pkg::*;
#(
  parameter longint unsigned CLK_HZ    = 250_000_000,
  parameter int unsigned     UV_NS     = 2000,
  parameter int unsigned     OC_CYCLES = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       master_en_i,
  input  logic [1:0] rail_en_i,
  input  logic       in_uv_i,
  input  logic       over_temp_i,
  input  logic [1:0] buck_oc_i,
  input  logic [1:0] buck_uv_i,
  input  logic [1:0] buck_ov_i,
  input  logic       boost_uv_i,
  input  logic       boost_ov_i,
  output logic       standby_on_o,
  output logic [2:0] run_o,
  output logic [1:0] crowbar_o,
  output logic [2:0] force_off_o,
  output logic       fault_latched_o
);
  localparam int unsigned UV_CYC = ns_to_cycles(CLK_HZ, UV_NS);
  localparam int SW = 13;

  logic [SW-1:0] raw, syn;
  assign raw = {master_en_i, rail_en_i, in_uv_i, over_temp_i, buck_oc_i,
                buck_uv_i, buck_ov_i, boost_uv_i, boost_ov_i};

  flag_sync #(.W(SW)) u_sync (.clk_i, .rst_ni, .d_i(raw), .q_o(syn));

  logic       m_s, in_uv_s, ot_s, bst_uv_s, bst_ov_s;
  logic [1:0] en_s, oc_s, uv_s, ov_s;
  assign {m_s, en_s, in_uv_s, ot_s, oc_s, uv_s, ov_s, bst_uv_s, bst_ov_s} = syn;

  logic       clr, hard_off;
  logic [1:0] oc_fire, uv_fire;
  logic       bst_uv_fire;
  assign clr      = !m_s;
  assign hard_off = in_uv_s || ot_s;

  for (genvar i = 0; i < N_BUCK; i++) begin : g_buck_tmr
    persist_timer #(.N(OC_CYCLES)) u_oc (
      .clk_i, .rst_ni, .clr_i(clr), .flag_i(oc_s[i]), .fire_o(oc_fire[i]));
    persist_timer #(.N(UV_CYC)) u_uv (
      .clk_i, .rst_ni, .clr_i(clr), .flag_i(uv_s[i]), .fire_o(uv_fire[i]));
  end

  persist_timer #(.N(UV_CYC)) u_bst_uv (
    .clk_i, .rst_ni, .clr_i(clr), .flag_i(bst_uv_s), .fire_o(bst_uv_fire));

  logic [1:0] oc_lat;
  logic       buck_uv_lat, bst_uv_lat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oc_lat      <= '0;
      buck_uv_lat <= 1'b0;
      bst_uv_lat  <= 1'b0;
    end else if (clr) begin
      oc_lat      <= '0;
      buck_uv_lat <= 1'b0;
      bst_uv_lat  <= 1'b0;
    end else begin
      oc_lat      <= oc_lat | oc_fire;
      buck_uv_lat <= buck_uv_lat | (|uv_fire);
      bst_uv_lat  <= bst_uv_lat | bst_uv_fire;
    end
  end

  logic common_off;
  assign common_off = hard_off || buck_uv_lat || bst_uv_lat;

  always_comb begin
    force_off_o[RAIL_HI]  = common_off || oc_lat[RAIL_HI];
    force_off_o[RAIL_LO]  = common_off || oc_lat[RAIL_LO];
    force_off_o[RAIL_BST] = common_off || oc_lat[RAIL_HI] || bst_ov_s;
    for (int i = 0; i < N_BUCK; i++) begin
      crowbar_o[i] = m_s && ov_s[i] && !force_off_o[i];
      run_o[i]     = m_s && en_s[i] && !force_off_o[i] && !ov_s[i];
    end
    run_o[RAIL_BST] = run_o[RAIL_HI] && !force_off_o[RAIL_BST];
  end

  assign standby_on_o    = m_s && !hard_off;
  assign fault_latched_o = (|oc_lat) || buck_uv_lat || bst_uv_lat;

  // R1: standby down means no converter runs
  a_r1_standby_gates_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !standby_on_o |-> run_o == 3'b000);
  // R3: an over-current latch only rises after the flag was present
  a_r3_oc_latch_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oc_lat[0]) |-> $past(oc_s[0]));
  // R5: boost undervoltage latch stops every converter
  a_r5_boost_uv_all_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bst_uv_lat |-> (run_o == 3'b000 && crowbar_o == 2'b00));
  // R6: a latched fault holds while the master enable stays high
  a_r6_latch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_latched_o && m_s) |=> fault_latched_o);
  // R7: crowbar and run never overlap on a buck
  a_r7_crowbar_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crowbar_o & run_o[1:0]) == 2'b00);
  // R8: boost overvoltage keeps the boost stopped
  a_r8_boost_ov_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bst_ov_s |-> !run_o[RAIL_BST]);
  // R9: hard shutdown forces every gate off
  a_r9_hard_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_off |-> (force_off_o == 3'b111 && !standby_on_o));
endmodule

// File: tb/rail_supervisor_test.sv
module rail_supervisor_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       master_en = 0, in_uv = 0, over_temp = 0, boost_uv = 0, boost_ov = 0;
  logic [1:0] rail_en = 0, buck_oc = 0, buck_uv = 0, buck_ov = 0;
  logic       standby_on, fault_latched;
  logic [2:0] run, force_off;
  logic [1:0] crowbar;

  rail_supervisor uut (
    .clk_i(clk), .rst_ni(rst_n), .master_en_i(master_en), .rail_en_i(rail_en),
    .in_uv_i(in_uv), .over_temp_i(over_temp), .buck_oc_i(buck_oc),
    .buck_uv_i(buck_uv), .buck_ov_i(buck_ov), .boost_uv_i(boost_uv),
    .boost_ov_i(boost_ov), .standby_on_o(standby_on), .run_o(run),
    .crowbar_o(crowbar), .force_off_o(force_off), .fault_latched_o(fault_latched));

  localparam int OCN = 8;
  localparam int UVN = 500;

  typedef struct {
    string      tag;
    logic [9:0] exp;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // {standby, fault, run[2:0], crowbar[1:0], force_off[2:0]}
  function automatic logic [9:0] pk(logic sb, logic fl, logic [2:0] r, logic [1:0] c, logic [2:0] f);
    return {sb, fl, r, c, f};
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_out(string tag, logic [9:0] e);
    item_t it;
    it.tag = tag;
    it.exp = e;
    q.push_back(it);
    @(negedge clk);
    #1;
  endtask

  // monitor: compare one queued item per falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        logic [9:0] act;
        it  = q.pop_front();
        act = {standby_on, fault_latched, run, crowbar, force_off};
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %b expected %b", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic pulse_oc(int idx, int n);
    buck_oc[idx] = 1'b1;
    tick(n);
    buck_oc[idx] = 1'b0;
    tick(4);
  endtask

  task automatic master_cycle();
    master_en = 0;
    tick(4);
    master_en = 1;
    tick(4);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    expect_out("R1 reset state", pk(0, 0, 3'b000, 2'b00, 3'b000));

    master_en = 1; tick(3);
    expect_out("R1 standby only", pk(1, 0, 3'b000, 2'b00, 3'b000));
    rail_en = 2'b01; tick(3);
    expect_out("R2 higher buck plus boost", pk(1, 0, 3'b101, 2'b00, 3'b000));
    rail_en = 2'b10; tick(3);
    expect_out("R2 lower buck only", pk(1, 0, 3'b010, 2'b00, 3'b000));
    rail_en = 2'b11; tick(3);
    expect_out("R2 all rails", pk(1, 0, 3'b111, 2'b00, 3'b000));

    buck_ov[1] = 1; tick(3);
    expect_out("R7 crowbar lower buck", pk(1, 0, 3'b101, 2'b10, 3'b000));
    buck_ov[1] = 0; tick(3);
    expect_out("R7 crowbar released", pk(1, 0, 3'b111, 2'b00, 3'b000));

    boost_ov = 1; tick(3);
    expect_out("R8 boost held off", pk(1, 0, 3'b011, 2'b00, 3'b100));
    boost_ov = 0; tick(3);
    expect_out("R8 boost resumes", pk(1, 0, 3'b111, 2'b00, 3'b000));

    pulse_oc(1, OCN - 1);
    expect_out("R3 short oc no latch", pk(1, 0, 3'b111, 2'b00, 3'b000));
    buck_oc[1] = 1; tick(OCN - 1);
    buck_oc[1] = 0; tick(1);
    buck_oc[1] = 1; tick(OCN - 1);
    buck_oc[1] = 0; tick(4);
    expect_out("R10 split bursts no latch", pk(1, 0, 3'b111, 2'b00, 3'b000));

    pulse_oc(1, OCN);
    expect_out("R3 R11 oc latches lower buck", pk(1, 1, 3'b101, 2'b00, 3'b010));
    tick(20);
    expect_out("R6 latch holds", pk(1, 1, 3'b101, 2'b00, 3'b010));
    master_en = 0; tick(4);
    expect_out("R6 master low clears", pk(0, 0, 3'b000, 2'b00, 3'b000));
    master_en = 1; tick(4);
    expect_out("R6 restart after clear", pk(1, 0, 3'b111, 2'b00, 3'b000));

    pulse_oc(0, OCN);
    expect_out("R3 oc higher buck stops boost", pk(1, 1, 3'b010, 2'b00, 3'b101));
    master_cycle();

    buck_uv[0] = 1; tick(UVN - 1); buck_uv[0] = 0; tick(4);
    expect_out("R4 short uv no latch", pk(1, 0, 3'b111, 2'b00, 3'b000));
    buck_uv[1] = 1; tick(UVN); buck_uv[1] = 0; tick(4);
    expect_out("R4 uv latches bucks and boost", pk(1, 1, 3'b000, 2'b00, 3'b111));
    master_cycle();

    boost_uv = 1; tick(UVN - 1); boost_uv = 0; tick(4);
    expect_out("R5 short boost uv no latch", pk(1, 0, 3'b111, 2'b00, 3'b000));
    boost_uv = 1; tick(UVN); boost_uv = 0; tick(4);
    expect_out("R5 boost uv latches all", pk(1, 1, 3'b000, 2'b00, 3'b111));
    buck_ov[0] = 1; tick(3);
    expect_out("R5 no crowbar while latched", pk(1, 1, 3'b000, 2'b00, 3'b111));
    buck_ov[0] = 0;
    master_cycle();

    over_temp = 1; tick(3);
    expect_out("R9 over-temp all off", pk(0, 0, 3'b000, 2'b00, 3'b111));
    over_temp = 0; tick(3);
    expect_out("R9 over-temp recovers", pk(1, 0, 3'b111, 2'b00, 3'b000));
    in_uv = 1; tick(3);
    expect_out("R9 input uv all off", pk(0, 0, 3'b000, 2'b00, 3'b111));
    in_uv = 0; tick(3);
    expect_out("R9 input uv recovers", pk(1, 0, 3'b111, 2'b00, 3'b000));

    tick(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule